// File: doc/BRIEF.md
# Pipelined IDEA Block Encryptor

This block encrypts 64-bit blocks under 128-bit keys with the IDEA cipher and is fully pipelined. A block and its key are offered together with a valid flag on any clock cycle. The ciphertext appears with a matching valid flag a fixed number of cycles later. There is no stall input, so the producer may issue on every cycle. Each block's key travels down the pipeline beside it. Consecutive blocks may therefore use the same key or unrelated keys, which suits bulk encryption and key-search workloads alike.

The pipeline is eight identical rounds and a closing output stage. Each round is a keyed-word stage followed by a mixing stage:

- The keyed-word stage applies two modular multiplies and two modular adds. It takes 4 cycles.
- The mixing stage has an XOR/multiply/add network. It takes 10 cycles.

The subkeys for each stage come from fixed rotations of the block's own key, so scheduling the key costs only wiring. A synchronous reset drops every block in flight. It does not clear the data registers.

Top module: `ideaPipeCore`

## Requirements
- R1: With key 0x00010002000300040005000600070008 and plaintext 0x0000000100020003, the ciphertext is 0x11FBED2B01986DE5. Word 1 of a block and subkey 1 of a key occupy their most significant 16 bits.
- R2: `outValid` is high exactly 116 cycles after each cycle in which `inValid` was high and `rst` was low, and low at all other times.
- R3: A block may be accepted on every cycle, each with its own key. Results leave in the order the blocks entered, each matching IDEA encryption of that block under that key.
- R4: Inside every modular multiply, an all-zero word or an all-zero subkey stands for 65536. Blocks containing zero words, and the all-zero key, still encrypt correctly.
- R5: While `rst` is high at a clock edge, all blocks in flight are dropped. After reset, `outValid` stays low until 116 cycles after the first accepted block.
- R6: Whenever `outValid` is low, `outBlock` is all zeros.
- R7: Gaps in the `inValid` pattern reappear unchanged in `outValid` 116 cycles later. Each valid output carries the result for the block accepted at the matching input cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, drops in-flight blocks |
| inValid | input | 1 | Block and key on the inputs are to be encrypted |
| inBlock | input | 64 | Plaintext, word 1 in bits 63:48 |
| inKey | input | 128 | Key, first subkey in bits 127:112 |
| outValid | output | 1 | Ciphertext on `outBlock` is valid |
| outBlock | output | 64 | Ciphertext, zero when not valid |

## Verification
Two events can fall in the same cycle: a block can enter while another block leaves, and a reset can arrive while blocks are still in flight. The bench first issues back-to-back bursts, so every cycle both admits and retires a block. It then drives a random stream with gaps, so the output must reproduce the input gaps exactly. Finally it raises reset with a full pipeline. Each output cycle is judged against a table of expected valid flags and ciphertexts that an arithmetic reference model fills at issue time. The reset rewrites the table entries for every dropped block as expected-idle.

// File: rtl/ideaPkg.sv
package ideaPkg;
  localparam int WORD_W         = 16;
  localparam int NUM_WORDS      = 4;
  localparam int BLOCK_W        = WORD_W * NUM_WORDS;
  localparam int KEY_W          = 128;
  localparam int KEY_WORDS      = KEY_W / WORD_W;
  localparam int KEY_ROT        = 25;
  localparam int ROUNDS         = 8;
  localparam int KEYS_PER_TRANS = 4;
  localparam int KEYS_PER_MIX   = 2;
  localparam int KEYS_PER_ROUND = KEYS_PER_TRANS + KEYS_PER_MIX;
  localparam int MUL_LAT        = 3;
  localparam int TRANS_LAT      = MUL_LAT + 1;
  localparam int MIX_LAT        = 2 * MUL_LAT + 4;
  localparam int TOTAL_LAT      = ROUNDS * (TRANS_LAT + MIX_LAT) + TRANS_LAT;

  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic feed;    // a block is being offered this cycle
    logic retire;  // the last stage holds a live block
  } ideaStrobe_t;

  // word i of a block, word 0 in the most significant position
  function automatic word_t wordAt(input logic [BLOCK_W-1:0] blk, input int i);
    return blk[BLOCK_W-1-WORD_W*i -: WORD_W];
  endfunction

  // subkey number idx derived from the user key by whole-key rotation
  function automatic word_t subkeyAt(input logic [KEY_W-1:0] key, input int idx);
    int rot;
    logic [KEY_W-1:0] rk;
    rot = ((idx / KEY_WORDS) * KEY_ROT) % KEY_W;
    if (rot == 0) rk = key;
    else          rk = (key << rot) | (key >> (KEY_W - rot));
    return rk[KEY_W-1-WORD_W*(idx % KEY_WORDS) -: WORD_W];
  endfunction
endpackage

// File: rtl/ideaModMul.sv
// Multiplication modulo 2^16+1, zero operand meaning 2^16; three register stages.
module ideaModMul
  import ideaPkg::*;
(
  input  logic  clk,
  input  word_t opA,
  input  word_t opB,
  output word_t prod
);
  localparam int EXT_W  = WORD_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int HI_W   = PROD_W - WORD_W;
  localparam logic [HI_W-1:0] MODULUS = HI_W'((1 << WORD_W) + 1);

  logic [EXT_W-1:0]  aExt, bExt;
  logic [PROD_W-1:0] full;
  logic [HI_W-1:0]   loX, hiX;

  always_ff @(posedge clk) begin
    aExt <= (opA == '0) ? {1'b1, {WORD_W{1'b0}}} : {1'b0, opA};
    bExt <= (opB == '0) ? {1'b1, {WORD_W{1'b0}}} : {1'b0, opB};
  end

  always_ff @(posedge clk) begin
    full <= aExt * bExt;
  end

  assign loX = {{(HI_W-WORD_W){1'b0}}, full[WORD_W-1:0]};
  assign hiX = full[PROD_W-1:WORD_W];

  // residue 2^16 truncates to zero, which is the encoding of 2^16
  always_ff @(posedge clk) begin
    prod <= (loX >= hiX) ? WORD_W'(loX - hiX) : WORD_W'(loX + MODULUS - hiX);
  end
endmodule

// File: rtl/ideaDelay.sv
module ideaDelay #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      logic [WIDTH-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        stage[0] <= din;
        for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ideaTransHalf.sv
// Keyed-word half-round: multiply words 1 and 4, add to words 2 and 3.
module ideaTransHalf
  import ideaPkg::*;
#(
  parameter int FIRST_KEY = 0,
  parameter bit SWAP_IN   = 1'b0
) (
  input  logic               clk,
  input  logic [BLOCK_W-1:0] blkIn,
  input  logic [KEY_W-1:0]   keyIn,
  output logic [BLOCK_W-1:0] blkOut
);
  word_t w0, w1, w2, w3;
  word_t k0, k1, k2, k3;
  word_t m0, m3;
  logic [2*WORD_W-1:0] sumMid, sumMidD;

  assign w0 = wordAt(blkIn, 0);
  assign w1 = SWAP_IN ? wordAt(blkIn, 2) : wordAt(blkIn, 1);
  assign w2 = SWAP_IN ? wordAt(blkIn, 1) : wordAt(blkIn, 2);
  assign w3 = wordAt(blkIn, 3);

  assign k0 = subkeyAt(keyIn, FIRST_KEY);
  assign k1 = subkeyAt(keyIn, FIRST_KEY + 1);
  assign k2 = subkeyAt(keyIn, FIRST_KEY + 2);
  assign k3 = subkeyAt(keyIn, FIRST_KEY + 3);

  ideaModMul mulHead_i (.clk(clk), .opA(w0), .opB(k0), .prod(m0));
  ideaModMul mulTail_i (.clk(clk), .opA(w3), .opB(k3), .prod(m3));

  assign sumMid = {w1 + k1, w2 + k2};

  ideaDelay #(.WIDTH(2*WORD_W), .DEPTH(MUL_LAT)) sumAlign_i (
    .clk(clk), .din(sumMid), .dout(sumMidD)
  );

  always_ff @(posedge clk) begin
    blkOut <= {m0, sumMidD, m3};
  end
endmodule

// File: rtl/ideaMangleHalf.sv
// Mixing half-round: XOR pairs, multiply-add-multiply-add, XOR back, middle words exchanged.
module ideaMangleHalf
  import ideaPkg::*;
#(
  parameter int FIRST_KEY = 4
) (
  input  logic               clk,
  input  logic [BLOCK_W-1:0] blkIn,
  input  logic [KEY_W-1:0]   keyIn,
  output logic [BLOCK_W-1:0] blkOut
);
  // cycle at which each intermediate becomes available (input register = cycle 1)
  localparam int T0_AT = 1 + MUL_LAT;
  localparam int H_AT  = T0_AT + 1;
  localparam int T1_AT = H_AT + MUL_LAT;
  localparam int T2_AT = T1_AT + 1;

  logic [BLOCK_W-1:0] rBlk, rBlkD;
  word_t rKey5, rKey6, key6D;
  word_t eMix, fMix, fMixD;
  word_t t0, t0D, t1, t1D, hSum, t2;

  always_ff @(posedge clk) begin
    rBlk  <= blkIn;
    rKey5 <= subkeyAt(keyIn, FIRST_KEY);
    rKey6 <= subkeyAt(keyIn, FIRST_KEY + 1);
  end

  assign eMix = wordAt(rBlk, 0) ^ wordAt(rBlk, 2);
  assign fMix = wordAt(rBlk, 1) ^ wordAt(rBlk, 3);

  ideaModMul mulFirst_i (.clk(clk), .opA(eMix), .opB(rKey5), .prod(t0));

  ideaDelay #(.WIDTH(WORD_W), .DEPTH(T0_AT-1)) fAlign_i (.clk(clk), .din(fMix), .dout(fMixD));
  ideaDelay #(.WIDTH(WORD_W), .DEPTH(H_AT-1))  kAlign_i (.clk(clk), .din(rKey6), .dout(key6D));

  always_ff @(posedge clk) begin
    hSum <= fMixD + t0;
  end

  ideaModMul mulSecond_i (.clk(clk), .opA(hSum), .opB(key6D), .prod(t1));

  ideaDelay #(.WIDTH(WORD_W), .DEPTH(T1_AT-T0_AT)) t0Align_i (.clk(clk), .din(t0), .dout(t0D));
  ideaDelay #(.WIDTH(WORD_W), .DEPTH(T2_AT-T1_AT)) t1Align_i (.clk(clk), .din(t1), .dout(t1D));
  ideaDelay #(.WIDTH(BLOCK_W), .DEPTH(T2_AT-1))    xAlign_i  (.clk(clk), .din(rBlk), .dout(rBlkD));

  always_ff @(posedge clk) begin
    t2 <= t0D + t1;
  end

  always_ff @(posedge clk) begin
    blkOut <= {wordAt(rBlkD, 0) ^ t1D,
               wordAt(rBlkD, 2) ^ t1D,
               wordAt(rBlkD, 1) ^ t2,
               wordAt(rBlkD, 3) ^ t2};
  end
endmodule

// File: rtl/ideaDatapath.sv
module ideaDatapath
  import ideaPkg::*;
(
  input  logic               clk,
  input  ideaStrobe_t        strobes,
  input  logic [BLOCK_W-1:0] inBlock,
  input  logic [KEY_W-1:0]   inKey,
  output logic [BLOCK_W-1:0] outBlock
);
  logic [BLOCK_W-1:0] blkChain [ROUNDS+1];
  logic [KEY_W-1:0]   keyChain [ROUNDS+1];
  logic [BLOCK_W-1:0] midBlk   [ROUNDS];
  logic [KEY_W-1:0]   midKey   [ROUNDS];
  logic [BLOCK_W-1:0] finBlk;

  // idle cycles feed zeros so the pipeline does not toggle on stale inputs
  assign blkChain[0] = strobes.feed ? inBlock : '0;
  assign keyChain[0] = strobes.feed ? inKey   : '0;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    ideaTransHalf #(.FIRST_KEY(KEYS_PER_ROUND*r), .SWAP_IN(1'b0)) trans_i (
      .clk(clk), .blkIn(blkChain[r]), .keyIn(keyChain[r]), .blkOut(midBlk[r])
    );
    ideaDelay #(.WIDTH(KEY_W), .DEPTH(TRANS_LAT)) transKey_i (
      .clk(clk), .din(keyChain[r]), .dout(midKey[r])
    );
    ideaMangleHalf #(.FIRST_KEY(KEYS_PER_ROUND*r + KEYS_PER_TRANS)) mix_i (
      .clk(clk), .blkIn(midBlk[r]), .keyIn(midKey[r]), .blkOut(blkChain[r+1])
    );
    ideaDelay #(.WIDTH(KEY_W), .DEPTH(MIX_LAT)) mixKey_i (
      .clk(clk), .din(midKey[r]), .dout(keyChain[r+1])
    );
  end

  // closing stage undoes the middle-word exchange of the last round
  ideaTransHalf #(.FIRST_KEY(KEYS_PER_ROUND*ROUNDS), .SWAP_IN(1'b1)) outStage_i (
    .clk(clk), .blkIn(blkChain[ROUNDS]), .keyIn(keyChain[ROUNDS]), .blkOut(finBlk)
  );

  assign outBlock = strobes.retire ? finBlk : '0;
endmodule

// File: rtl/ideaCtrl.sv
module ideaCtrl
  import ideaPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        outValid,
  output ideaStrobe_t strobes
);
  logic [TOTAL_LAT-1:0] livePipe;

  always_ff @(posedge clk) begin
    if (rst) livePipe <= '0;
    else     livePipe <= {livePipe[TOTAL_LAT-2:0], inValid};
  end

  assign outValid       = livePipe[TOTAL_LAT-1];
  assign strobes.feed   = inValid;
  assign strobes.retire = livePipe[TOTAL_LAT-1];
endmodule

// File: rtl/ideaPipeCore.sv
module ideaPipeCore
  import ideaPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [BLOCK_W-1:0] inBlock,
  input  logic [KEY_W-1:0]   inKey,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outBlock
);
  ideaStrobe_t strobes;

  ideaCtrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .strobes(strobes)
  );

  ideaDatapath dp_i (
    .clk(clk), .strobes(strobes), .inBlock(inBlock), .inKey(inKey), .outBlock(outBlock)
  );
endmodule

// File: rtl/ideaPipeCore_chk.sv
module ideaPipeCore_chk
  import ideaPkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               outValid,
  input logic [BLOCK_W-1:0] outBlock
);
  localparam int CNT_W = $clog2(TOTAL_LAT + 2) + 1;

  logic [CNT_W-1:0] sinceRst;
  logic [CNT_W-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      inFlight <= '0;
    end else begin
      if (sinceRst < CNT_W'(TOTAL_LAT)) sinceRst <= sinceRst + 1'b1;
      inFlight <= inFlight + CNT_W'(inValid) - CNT_W'(outValid);
    end
  end

  // R6: idle output carries zeros
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outBlock == '0));

  // R5: nothing emerges before a full latency has elapsed since reset
  p_no_early_r5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < CNT_W'(TOTAL_LAT)) |-> !outValid);

  // R3: blocks in flight never exceed the pipeline depth
  p_inflight_bound_r3: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CNT_W'(TOTAL_LAT));

  // R2: every result has an accepted block behind it
  p_out_has_source_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != '0));
endmodule

bind ideaPipeCore ideaPipeCore_chk chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .outBlock(outBlock)
);

// File: tb/ideaPipeCore_tb_top.sv
module ideaPipeCore_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 116;
  localparam int SLOTS      = 8192;
  localparam int WATCHDOG   = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [63:0]  inBlock = '0;
  logic [127:0] inKey = '0;
  logic         outValid;
  logic [63:0]  outBlock;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  bit          expV [SLOTS];
  logic [63:0] expD [SLOTS];
  string       expT [SLOTS];

  ideaPipeCore dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inBlock(inBlock), .inKey(inKey),
    .outValid(outValid), .outBlock(outBlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] refMul(input logic [15:0] a, input logic [15:0] b);
    logic [33:0] aa, bb, p;
    aa = (a == 0) ? 34'd65536 : {18'd0, a};
    bb = (b == 0) ? 34'd65536 : {18'd0, b};
    p  = (aa * bb) % 34'd65537;
    return p[15:0];
  endfunction

  function automatic logic [63:0] refEncrypt(input logic [63:0] pt, input logic [127:0] key);
    logic [15:0]  sk [52];
    logic [127:0] k;
    logic [15:0]  x1, x2, x3, x4, s2, s3, t0, t1, t2;
    k = key;
    for (int i = 0; i < 52; i++) begin
      sk[i] = k[127-16*(i%8) -: 16];
      if (i % 8 == 7) k = {k[102:0], k[127:103]};
    end
    {x1, x2, x3, x4} = pt;
    for (int r = 0; r < 8; r++) begin
      x1 = refMul(x1, sk[6*r]);
      x2 = x2 + sk[6*r+1];
      x3 = x3 + sk[6*r+2];
      x4 = refMul(x4, sk[6*r+3]);
      t0 = refMul(x1 ^ x3, sk[6*r+4]);
      t1 = refMul((x2 ^ x4) + t0, sk[6*r+5]);
      t2 = t0 + t1;
      s2 = x2; s3 = x3;
      x1 = x1 ^ t1;
      x4 = x4 ^ t2;
      x2 = s3 ^ t1;
      x3 = s2 ^ t2;
    end
    return {refMul(x1, sk[48]), x3 + sk[49], x2 + sk[50], refMul(x4, sk[51])};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // compare this cycle's outputs, then drive the next inputs and book their result
  task automatic step(input bit v, input logic [63:0] blk, input logic [127:0] key,
                      input bit r, input string tagV, input string tagIdle);
    int n, idx, dst;
    bit ok;
    @(negedge clk);
    n   = cyc;
    idx = n % SLOTS;
    if (expV[idx]) ok = (outValid === 1'b1) && (outBlock === expD[idx]);
    else           ok = (outValid === 1'b0) && (outBlock === 64'h0);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: got valid=%0b block=%h, expected valid=%0b block=%h",
               expT[idx], n, outValid, outBlock, expV[idx], expV[idx] ? expD[idx] : 64'h0);
    end
    rst     = r;
    inValid = v;
    inBlock = blk;
    inKey   = key;
    if (r) begin
      for (int i = 1; i <= LAT; i++) begin
        expV[(n+i) % SLOTS] = 1'b0;
        expT[(n+i) % SLOTS] = "R5";
      end
    end else begin
      dst = (n + LAT) % SLOTS;
      expV[dst] = v;
      expD[dst] = v ? refEncrypt(blk, key) : 64'h0;
      expT[dst] = v ? tagV : tagIdle;
    end
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      expV[i] = 1'b0;
      expD[i] = '0;
      expT[i] = "R5";
    end
    done = 1'b0;
  end

  initial begin : main
    logic [127:0] key, lastKey;
    logic [63:0]  blk;
    // R5: reset state, outputs idle and zero
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b1, "R5", "R5");

    // R1: reference model matches the published vector
    checks++;
    if (refEncrypt(64'h0000000100020003, 128'h00010002000300040005000600070008)
        !== 64'h11FBED2B01986DE5) begin
      fails++;
      $display("FAIL R1 model: got %h expected %h",
               refEncrypt(64'h0000000100020003, 128'h00010002000300040005000600070008),
               64'h11FBED2B01986DE5);
    end
    // R1/R2: single block; idle cycles around it must stay low (R2)
    step(1'b1, 64'h0000000100020003, 128'h00010002000300040005000600070008, 1'b0, "R1", "R2");
    for (int i = 0; i < LAT + 4; i++) step(1'b0, '0, '0, 1'b0, "R2", "R2");

    // R4: sweep of zero-word patterns against zero, all-ones and random keys
    for (int kk = 0; kk < 3; kk++) begin
      key = (kk == 0) ? 128'h0 :
            (kk == 1) ? {128{1'b1}} : {$urandom, $urandom, $urandom, $urandom};
      for (int m = 0; m < 16; m++) begin
        for (int w = 0; w < 4; w++)
          blk[63-16*w -: 16] = m[w] ? 16'h0 : 16'($urandom);
        step(1'b1, blk, key, 1'b0, "R4", "R6");
      end
    end

    // R3: back-to-back burst, fresh or reused keys
    lastKey = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 200; i++) begin
      key = (i % 4 == 3) ? lastKey : {$urandom, $urandom, $urandom, $urandom};
      lastKey = key;
      step(1'b1, {$urandom, $urandom}, key, 1'b0, "R3", "R6");
    end

    // R7: random gaps, idle slots must stay idle and zero
    for (int i = 0; i < 150; i++)
      step(1'($urandom % 2), {$urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R7", "R7");

    // R5: reset with a full pipeline, nothing may emerge afterwards
    for (int i = 0; i < 50; i++)
      step(1'b1, {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R3", "R6");
    step(1'b1, {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b1, "R5", "R5");
    step(1'b0, '0, '0, 1'b1, "R5", "R5");
    for (int i = 0; i < LAT + 10; i++) step(1'b0, '0, '0, 1'b0, "R5", "R6");

    // R1 again after reset, then drain
    step(1'b1, 64'h0000000100020003, 128'h00010002000300040005000600070008, 1'b0, "R1", "R6");
    for (int i = 0; i < LAT + 4; i++) step(1'b0, '0, '0, 1'b0, "R6", "R6");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule